// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one timer channel behind a small word-addressed register port. Software programs a limit, picks a counting mode, a counter width and a clock prescaler, and then enables the channel. The counter steps down once per prescaled tick. When a count runs out, a raw interrupt flag is set. The flag stays set until software writes the clear offset. A level interrupt output presents the flag gated by an enable bit.

Three modes exist. In free-running mode the counter wraps to the all-ones value of the selected width. In periodic mode it reloads from the limit. In one-shot mode it halts at zero. A limit written at offset 0 also reloads the counter at once. A limit written at offset 6 waits for the next natural reload.

Top module: `interval_timer`

## Requirements
- R1: Register word offsets are 0 load, 1 current count, 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0) and 6 background load. Offsets 0 and 6 both read the limit. Offsets 3 and 7 read as zero.
- R2: After reset the control register reads 0x20, and limit, count, raw status and irq_o are all zero.
- R3: A write at offset 0 stores the limit and loads the counter with it in the same edge. If a tick falls in that cycle, the write wins and no interrupt is raised.
- R4: A write at offset 6 stores only the limit. The count is untouched until the next reload.
- R5: Writes at offset 1 have no effect on the count.
- R6: Control bits [3:2] select the prescaler: 0 divides by 1, 1 by 16, 2 by 256, and 3 by 1. While control bit 7 is set, the counter steps down once per prescaled tick.
- R7: With bit 6 set and bit 0 clear (periodic), a tick that finds the count at 1 or 0 raises the interrupt and loads the limit. The period is therefore the limit in ticks.
- R8: With bits 6 and 0 both clear (free-running), the reload value is 0xFFFF when bit 1 is clear and 0xFFFFFFFF when bit 1 is set.
- R9: With bit 0 set (one-shot, which takes priority over bit 6), a tick at count 1 raises the interrupt and leaves the count at 0. After that the count stays at 0 and raises nothing more.
- R10: With bit 1 clear (16-bit), only the low 16 bits of the count and the limit take part, and bits [31:16] of both read as zero.
- R11: Any write at offset 3 clears the raw flag. An expiry in the same cycle takes priority and leaves the flag set.
- R12: Masked status and irq_o equal the raw flag ANDed with control bit 5.
- R13: A control write restarts the prescaler, and the new settings govern from the following cycle. Bit 4 is stored as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the selected offset |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Two events can fall in the same cycle: a clear write and an expiry. A directed sequence uses the bench model to find the cycle whose edge will expire the count, issues the clear in exactly that cycle, and then expects the raw flag to stay set. A load write that lands on a tick is a second collision of the same kind. Both collisions also come up under random stimulus with small limits. Every cycle, the bench compares irq_o and one register read against a cycle model built from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_LOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_MSK   = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_BGLD  = 3'd6;

  localparam int CTL_ONESHOT = 0;
  localparam int CTL_WIDE    = 1;
  localparam int CTL_PS_LO   = 2;
  localparam int CTL_IE      = 5;
  localparam int CTL_PER     = 6;
  localparam int CTL_EN      = 7;

  localparam logic [7:0] CTRL_RST  = 8'h20;
  localparam logic [7:0] CTRL_KEEP = 8'hEF;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } tmr_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_A_LOG2 = 4,
  parameter int DIV_B_LOG2 = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int PS_W = DIV_B_LOG2;
  localparam logic [PS_W-1:0] DIV_A_M1 = PS_W'((1 << DIV_A_LOG2) - 1);
  localparam logic [PS_W-1:0] DIV_B_M1 = PS_W'((1 << DIV_B_LOG2) - 1);

  logic [PS_W-1:0] pre_q, div_m1;

  always_comb begin
    unique case (sel_i)
      2'd1:    div_m1 = DIV_A_M1;
      2'd2:    div_m1 = DIV_B_M1;
      default: div_m1 = '0;
    endcase
  end

  assign tick_o = run_i && (pre_q == div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (!run_i || restart_i) pre_q <= '0;
    else if (tick_o)              pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= div_m1); // R6
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tmr_mode_e        mode_i,
  input  logic             wide_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] NARROW_MASK =
    {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, mask, cnt_eff, reload_val;
  logic             at_end;

  assign mask       = wide_i ? '1 : NARROW_MASK;
  assign cnt_eff    = cnt_q & mask;
  assign reload_val = (mode_i == MODE_FREE) ? mask : (limit_i & mask);
  assign at_end     = (cnt_eff <= CNT_W'(1));
  assign expire_o   = tick_i && !load_i &&
                      ((mode_i == MODE_ONESHOT) ? (cnt_eff == CNT_W'(1)) : at_end);
  assign cnt_o      = cnt_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i & mask;
    else if (tick_i) begin
      if (at_end)      cnt_q <= (mode_i == MODE_ONESHOT) ? '0 : reload_val;
      else             cnt_q <= cnt_eff - CNT_W'(1);
    end
  end

  AST_LOAD_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i & mask)); // R3
  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_eff > CNT_W'(1)) |=> cnt_q == $past(cnt_eff) - CNT_W'(1)); // R6
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ONESHOT && cnt_q == '0 && !load_i) |=> cnt_q == '0); // R9
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NARROW_W   = 16,
  parameter int DIV_A_LOG2 = 4,
  parameter int DIV_B_LOG2 = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] NARROW_MASK =
    {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] limit_q, cnt, rd_mask;
  logic             raw_q, tick, expire;
  logic             wr_load, wr_bg, wr_ctrl, wr_clr;
  tmr_mode_e        mode;

  assign wr_load = wr_i && (addr_i == OFF_LOAD);
  assign wr_bg   = wr_i && (addr_i == OFF_BGLD);
  assign wr_ctrl = wr_i && (addr_i == OFF_CTRL);
  assign wr_clr  = wr_i && (addr_i == OFF_CLR);

  always_comb begin
    if (ctrl_q[CTL_ONESHOT])  mode = MODE_ONESHOT;
    else if (ctrl_q[CTL_PER]) mode = MODE_PERIODIC;
    else                      mode = MODE_FREE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_ctrl)          ctrl_q  <= wdata_i[7:0] & CTRL_KEEP;
      if (wr_load || wr_bg) limit_q <= wdata_i;
      if (expire)           raw_q   <= 1'b1;
      else if (wr_clr)      raw_q   <= 1'b0;
    end
  end

  tmr_prescale #(
    .DIV_A_LOG2(DIV_A_LOG2),
    .DIV_B_LOG2(DIV_B_LOG2)
  ) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q[CTL_EN]),
    .restart_i(wr_ctrl),
    .sel_i    (ctrl_q[CTL_PS_LO+1:CTL_PS_LO]),
    .tick_o   (tick)
  );

  tmr_count #(
    .CNT_W   (CNT_W),
    .NARROW_W(NARROW_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (mode),
    .wide_i    (ctrl_q[CTL_WIDE]),
    .load_i    (wr_load),
    .load_val_i(wdata_i),
    .limit_i   (limit_q),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  assign rd_mask = ctrl_q[CTL_WIDE] ? '1 : NARROW_MASK;
  assign irq_o   = raw_q && ctrl_q[CTL_IE];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_LOAD, OFF_BGLD: rdata_o = limit_q & rd_mask;
      OFF_COUNT:          rdata_o = cnt;
      OFF_CTRL:           rdata_o = CNT_W'(ctrl_q);
      OFF_RAW:            rdata_o = CNT_W'(raw_q);
      OFF_MSK:            rdata_o = CNT_W'(irq_o);
      default:            rdata_o = '0;
    endcase
  end

  AST_RAW_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> raw_q); // R11
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !expire) |=> !raw_q); // R11
  AST_BG_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bg && !tick) |=> $stable(cnt)); // R4
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  m_ctrl;
  logic [31:0] m_limit, m_cnt;
  logic        m_raw;
  int          m_pre;

  interval_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [31:0] msk();
    return m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic int divn();
    return (m_ctrl[3:2] == 2'd1) ? 16 : (m_ctrl[3:2] == 2'd2) ? 256 : 1;
  endfunction

  function automatic logic [31:0] mread(int a);
    case (a)
      0, 6: return m_limit & msk();
      1:    return m_cnt & msk();
      2:    return {24'd0, m_ctrl};
      4:    return {31'd0, m_raw};
      5:    return {31'd0, m_raw & m_ctrl[5]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag(int a);
    case (a)
      0: return "R3";
      1: return "R6";
      2: return "R13";
      4: return "R11";
      5: return "R12";
      6: return "R4";
      default: return "R1";
    endcase
  endfunction

  // true when the coming edge will expire the count (no write that cycle)
  function automatic bit will_expire();
    logic [31:0] ce;
    ce = m_cnt & msk();
    if (!(m_ctrl[7] && m_pre == divn() - 1)) return 0;
    return m_ctrl[0] ? (ce == 32'd1) : (ce <= 32'd1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(int a, string req);
    addr_i = 3'(a);
    #1;
    check(req, rdata_o, mread(a));
  endtask

  task automatic irq_check();
    check("R12", {31'd0, irq_o}, {31'd0, m_raw & m_ctrl[5]});
  endtask

  // one clock cycle, entered and left at a negedge
  task automatic cyc(bit w, int a, logic [31:0] d);
    logic [31:0] ce, n_cnt, n_limit;
    logic [7:0]  n_ctrl;
    logic        n_raw, tick, ld, cw, ex;
    int          n_pre;
    wr_i = w; addr_i = 3'(a); wdata_i = d;
    tick = m_ctrl[7] && (m_pre == divn() - 1);
    cw   = w && a == 2;
    ld   = w && a == 0;
    ce   = m_cnt & msk();
    n_pre = (!m_ctrl[7] || cw) ? 0 : tick ? 0 : m_pre + 1;
    ex = tick && !ld && (m_ctrl[0] ? (ce == 32'd1) : (ce <= 32'd1));
    n_cnt = m_cnt;
    if (ld) n_cnt = d & msk();
    else if (tick) begin
      if (ce <= 32'd1) n_cnt = m_ctrl[0] ? 32'd0 : m_ctrl[6] ? (m_limit & msk()) : msk();
      else             n_cnt = ce - 32'd1;
    end
    n_limit = (w && (a == 0 || a == 6)) ? d : m_limit;
    n_ctrl  = cw ? (d[7:0] & 8'hEF) : m_ctrl;
    n_raw   = ex ? 1'b1 : (w && a == 3) ? 1'b0 : m_raw;
    @(posedge clk_i);
    m_pre = n_pre; m_cnt = n_cnt; m_limit = n_limit; m_ctrl = n_ctrl; m_raw = n_raw;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 32'd0);
      irq_check();
      rd_check(1, "R6");
    end
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    m_ctrl = 8'h20; m_limit = '0; m_cnt = '0; m_raw = 1'b0; m_pre = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 reset state
    addr_i = 3'd2; #1; check("R2", rdata_o, 32'h20);
    check("R2", {31'd0, irq_o}, 32'd0);
    for (int a = 0; a < 8; a++) rd_check(a, "R2");

    // R5 value write ignored
    cyc(1, 0, 32'd100);
    cyc(1, 1, 32'd7);
    addr_i = 3'd1; #1; check("R5", rdata_o, 32'd100);

    // R10 narrow mode masks upper bits (timer disabled, ctrl 0x20)
    cyc(1, 0, 32'h1234_5678);
    addr_i = 3'd0; #1; check("R10", rdata_o, 32'h0000_5678);
    addr_i = 3'd1; #1; check("R10", rdata_o, 32'h0000_5678);
    rd_check(6, "R1");
    rd_check(3, "R1");

    // R9 one-shot, wide, div1
    cyc(1, 2, 32'hA3);
    cyc(1, 0, 32'd3);
    idle(8);
    addr_i = 3'd1; #1; check("R9", rdata_o, 32'd0);
    addr_i = 3'd4; #1; check("R9", rdata_o, 32'd1);
    cyc(1, 3, 32'd0);
    idle(5);
    addr_i = 3'd4; #1; check("R9", rdata_o, 32'd0);

    // R7 periodic and R11 clear colliding with expiry
    cyc(1, 2, 32'hE2);
    cyc(1, 0, 32'd4);
    idle(10);
    for (int i = 0; i < 10; i++) begin
      if (will_expire()) begin
        cyc(1, 3, 32'd0);
        addr_i = 3'd4; #1; check("R11", rdata_o, 32'd1);
        break;
      end
      cyc(0, 0, 32'd0);
    end
    rd_check(1, "R7");

    // R4 background load takes effect at next reload
    cyc(1, 6, 32'd9);
    rd_check(1, "R4");
    idle(14);

    // R8 free running narrow and R6 prescale 16
    cyc(1, 2, 32'hA4);
    cyc(1, 0, 32'd2);
    idle(40);
    rd_check(1, "R8");
    cyc(1, 2, 32'hAC);  // prescale code 3
    idle(6);

    // random phase
    for (int n = 0; n < 5000; n++) begin
      int r, a;
      logic [31:0] d;
      r = int'($urandom % 100);
      if (r < 4) begin
        d = $urandom & 32'hEF;
        if (d[3:2] == 2'd2 && ($urandom % 4) != 0) d[3:2] = 2'd1;
        d[7] = ($urandom % 5) != 0;
        cyc(1, 2, d);
      end else if (r < 9) begin
        d = (($urandom % 8) == 0) ? $urandom : ($urandom % 40);
        cyc(1, 0, d);
      end else if (r < 12) begin
        cyc(1, 6, $urandom % 40);
      end else if (r < 16) begin
        cyc(1, 3, $urandom);
      end else if (r < 18) begin
        cyc(1, 1, $urandom);
      end else begin
        cyc(0, 0, 32'd0);
      end
      irq_check();
      a = int'($urandom % 8);
      rd_check(a, rtag(a));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule